// File: doc/BRIEF.md
# Yaw-Rate PWM Encoder

This block turns a signed fixed-point angular-rate sample from a gyro into a fixed-frequency pulse-width-modulated output. The pulse width carries the rate to a second controller over a single wire, as a fallback link. Each accepted sample is converted to degrees per second and clamped to the supported span. It is then mapped linearly onto a restricted duty window, 10% to 90% of the period, with zero rate at the midpoint. An output that is idle, or stuck at either rail, therefore never looks like a valid reading.

A sample is taken only when its strobe is high and its integrity flag says the frame passed its checksum. Otherwise the previous pulse width is kept. The conversion uses one constant multiply and one shift. A free-running counter, advanced by a prescaler, sets the PWM period. A new pulse width is loaded only when that counter wraps, so every period shows either the old width or the new one and never a mix of the two. With the default parameters, a 125 MHz clock, a prescale of 10 and a counter top of 62499 give a 200 Hz output.

Top module: `yaw_pwm_encoder`

## Requirements
- R1: For an accepted raw sample g, the compare level is floor(PWM_TOP × (0.1 + 0.8 × (r/4000 + 0.5))), where r = g / 655360 is the rate in degrees per second. The result is within one count of that value, and the output is high for level × PRESCALE clock cycles per period.
- R2: The rate is clamped to ±2000 degrees per second, which is a raw value of ±1310720000. Any raw sample beyond the limit gives the same level as the limit itself.
- R3: A zero rate gives the midpoint level, floor(PWM_TOP / 2), which is 50% duty.
- R4: Every accepted level lies inside the duty window, from floor(0.1 × PWM_TOP) to floor(0.9 × PWM_TOP), within one count.
- R5: A sample is accepted only on a cycle where gyro_valid and gyro_ok are both 1. A strobe with gyro_ok at 0, or a change of gyro_rate with gyro_valid at 0, leaves the pulse width unchanged.
- R6: The PWM counter runs from 0 to PWM_TOP and then wraps to 0. The period is (PWM_TOP+1) × PRESCALE clock cycles. pwm_out is 1 while the counter is below the active level.
- R7: A new level becomes active only at the counter wrap. Every complete high pulse therefore matches either the old level or the new one.
- R8: After reset the active level is 0, and pwm_out stays low until the first accepted sample takes effect at a wrap.
- R9: The PWM counter advances once every PRESCALE clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gyro_valid | input | 1 | Sample strobe |
| gyro_ok | input | 1 | 1 when the frame carrying the sample passed its checksum |
| gyro_rate | input | GYRO_W | Signed raw rate, 655360 counts per degree per second |
| pwm_out | output | 1 | Pulse-width-modulated rate output |

## Verification
An accepted sample is registered by the clamp stage on its strobe edge and scaled one edge later. It then waits for the next counter wrap, which can be up to one full period away, before the pulse width changes. After each sample the bench therefore waits one full period plus a small margin. It then measures the first complete high pulse that starts at a rising edge, with all outputs sampled on the falling clock edge, and allows one count (PRESCALE cycles) of tolerance. For the wrap-only update, the bench changes the level in the middle of a high pulse. It then checks every complete pulse over the next several periods against the old and new widths.

// File: rtl/yaw_pwm_pkg.sv
package yaw_pwm_pkg;

   // fraction bits of the fixed-point duty scaler
   localparam int unsigned FRAC_BITS = 32;

   // raw sample value that corresponds to the rate limit
   function automatic longint raw_limit(input int limit_dps, input int counts_per_dps);
      return longint'(limit_dps) * longint'(counts_per_dps);
   endfunction

   // slope: level counts per raw count, scaled by 2^FRAC_BITS, rounded
   function automatic longint duty_gain(input int top, input int lo_pct, input int hi_pct,
                                        input int limit_dps, input int counts_per_dps);
      real num;
      real den;
      num = real'(top) * real'(hi_pct - lo_pct) * (2.0 ** FRAC_BITS);
      den = 200.0 * real'(limit_dps) * real'(counts_per_dps);
      return longint'(num / den);
   endfunction

   // level at zero rate, scaled by 2^FRAC_BITS
   function automatic longint duty_offset(input int top, input int lo_pct, input int hi_pct);
      real v;
      v = real'(top) * real'(lo_pct + hi_pct) / 200.0;
      return longint'(v * (2.0 ** FRAC_BITS));
   endfunction

   // floor(top * pct / 100) for the window bounds
   function automatic int window_level(input int top, input int pct);
      return int'((longint'(top) * longint'(pct)) / 100);
   endfunction

endpackage

// File: rtl/yaw_rate_clamp.sv
module yaw_rate_clamp #(
   parameter int     GYRO_W    = 32,
   parameter longint LIMIT_RAW = 64'd1310720000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take,
   input  logic        [GYRO_W-1:0] raw_in,
   output logic signed [GYRO_W-1:0] rate_q,
   output logic                     rate_new
);

   localparam logic signed [63:0]       LIM64 = LIMIT_RAW;
   localparam logic signed [GYRO_W-1:0] LIM_P = LIM64[GYRO_W-1:0];
   localparam logic signed [GYRO_W-1:0] LIM_N = -LIM_P;

   logic signed [63:0]       raw_ext;
   logic signed [GYRO_W-1:0] clamped;

   assign raw_ext = {{(64-GYRO_W){raw_in[GYRO_W-1]}}, raw_in};

   always_comb begin
      if (raw_ext > LIM64)
         clamped = LIM_P;
      else if (raw_ext < -LIM64)
         clamped = LIM_N;
      else
         clamped = raw_ext[GYRO_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q   <= '0;
         rate_new <= 1'b0;
      end else begin
         rate_new <= take;
         if (take)
            rate_q <= clamped;
      end
   end

   // R2
   clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (rate_q <= LIM_P) && (rate_q >= LIM_N));

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(rate_q));

endmodule

// File: rtl/yaw_duty_scaler.sv
module yaw_duty_scaler #(
   parameter int     GYRO_W  = 32,
   parameter int     CNT_W   = 16,
   parameter longint GAIN    = 64'd81919,
   parameter longint OFFSET  = 64'd0,
   parameter int     FRAC    = 32,
   parameter int     LVL_MIN = 0,
   parameter int     LVL_MAX = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rate_new,
   input  logic signed [GYRO_W-1:0] rate_in,
   output logic        [CNT_W-1:0]  level_q
);

   localparam logic signed [63:0] GAIN64 = GAIN;
   localparam logic signed [63:0] OFF64  = OFFSET;

   logic signed [63:0] rate_ext;
   logic signed [63:0] acc;
   logic signed [63:0] shifted;
   logic [CNT_W-1:0]   level_d;

   assign rate_ext = {{(64-GYRO_W){rate_in[GYRO_W-1]}}, rate_in};
   assign acc      = rate_ext * GAIN64 + OFF64;
   assign shifted  = acc >>> FRAC;

   always_comb begin
      if (shifted[63])
         level_d = '0;
      else if (|shifted[62:CNT_W])
         level_d = '1;
      else
         level_d = shifted[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level_q <= '0;
      else if (rate_new)
         level_q <= level_d;
   end

   // R4
   level_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_new |=> (int'(level_q) >= LVL_MIN - 1) && (int'(level_q) <= LVL_MAX + 1));

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
   parameter int PRESCALE = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = rst_n;
      end else begin : g_div
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (div_q == LAST)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end

         assign tick = (div_q == LAST);

         // R9
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);

         // R9
         div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            div_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/pwm_compare_core.sv
module pwm_compare_core #(
   parameter int PWM_TOP = 62499,
   parameter int CNT_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] pend_level,
   output logic             pwm
);

   localparam logic [CNT_W-1:0] TOP_V = CNT_W'(PWM_TOP);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] active_q;
   logic             wrap;

   assign wrap = tick && (cnt_q == TOP_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= '0;
      end else if (tick) begin
         if (cnt_q == TOP_V) begin
            cnt_q    <= '0;
            active_q <= pend_level;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pwm = (cnt_q < active_q);

   // R6
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP_V);

   // R6
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));

   // R7
   level_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(active_q));

   // R9
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

endmodule

// File: rtl/yaw_pwm_encoder.sv
module yaw_pwm_encoder #(
   parameter int GYRO_W      = 32,
   parameter int RATE_SCALE  = 655360,
   parameter int RATE_LIMIT  = 2000,
   parameter int DUTY_LO_PCT = 10,
   parameter int DUTY_HI_PCT = 90,
   parameter int PWM_TOP     = 62499,
   parameter int PRESCALE    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gyro_valid,
   input  logic              gyro_ok,
   input  logic [GYRO_W-1:0] gyro_rate,
   output logic              pwm_out
);
   import yaw_pwm_pkg::*;

   localparam int     CNT_W     = $clog2(PWM_TOP + 1);
   localparam longint LIMIT_RAW = raw_limit(RATE_LIMIT, RATE_SCALE);
   localparam longint GAIN      = duty_gain(PWM_TOP, DUTY_LO_PCT, DUTY_HI_PCT,
                                            RATE_LIMIT, RATE_SCALE);
   localparam longint OFFSET    = duty_offset(PWM_TOP, DUTY_LO_PCT, DUTY_HI_PCT);
   localparam int     LVL_MIN   = window_level(PWM_TOP, DUTY_LO_PCT);
   localparam int     LVL_MAX   = window_level(PWM_TOP, DUTY_HI_PCT);

   generate
      if (DUTY_LO_PCT < 0 || DUTY_LO_PCT >= DUTY_HI_PCT || DUTY_HI_PCT > 100) begin : g_bad_window
         $error("duty window bounds out of order");
      end
      if (PRESCALE < 1 || PWM_TOP < 1) begin : g_bad_timer
         $error("prescale and counter top must be positive");
      end
      if (GYRO_W < 2 || GYRO_W > 48) begin : g_bad_width
         $error("gyro width out of supported span");
      end
      if (LIMIT_RAW >= (64'sd1 <<< (GYRO_W - 1))) begin : g_bad_limit
         $error("rate limit does not fit the sample width");
      end
   endgenerate

   logic                     take;
   logic signed [GYRO_W-1:0] rate_c;
   logic                     rate_new;
   logic [CNT_W-1:0]         level_p;
   logic                     tick;

   assign take = gyro_valid && gyro_ok;

   yaw_rate_clamp #(
      .GYRO_W    (GYRO_W),
      .LIMIT_RAW (LIMIT_RAW)
   ) u_clamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .raw_in   (gyro_rate),
      .rate_q   (rate_c),
      .rate_new (rate_new)
   );

   yaw_duty_scaler #(
      .GYRO_W  (GYRO_W),
      .CNT_W   (CNT_W),
      .GAIN    (GAIN),
      .OFFSET  (OFFSET),
      .FRAC    (FRAC_BITS),
      .LVL_MIN (LVL_MIN),
      .LVL_MAX (LVL_MAX)
   ) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_new (rate_new),
      .rate_in  (rate_c),
      .level_q  (level_p)
   );

   pwm_tick_gen #(
      .PRESCALE (PRESCALE)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   pwm_compare_core #(
      .PWM_TOP (PWM_TOP),
      .CNT_W   (CNT_W)
   ) u_pwm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .pend_level (level_p),
      .pwm        (pwm_out)
   );

   // R5
   reject_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !rate_new);

endmodule

// File: tb/tb_yaw_pwm_encoder.sv
module tb_yaw_pwm_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int TB_TOP     = 999;
   localparam int TB_PS      = 2;
   localparam int PER        = (TB_TOP + 1) * TB_PS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gyro_valid = 1'b0;
   logic        gyro_ok = 1'b0;
   logic [31:0] gyro_rate = '0;
   logic        pwm_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   yaw_pwm_encoder #(
      .PWM_TOP  (TB_TOP),
      .PRESCALE (TB_PS)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .gyro_valid (gyro_valid),
      .gyro_ok    (gyro_ok),
      .gyro_rate  (gyro_rate),
      .pwm_out    (pwm_out)
   );

   function automatic int exp_level(input longint g);
      real r;
      real d;
      r = real'(g) / 655360.0;
      if (r > 2000.0)  r = 2000.0;
      if (r < -2000.0) r = -2000.0;
      d = 0.1 + 0.8 * (r / 4000.0 + 0.5);
      return $rtoi(d * real'(TB_TOP));
   endfunction

   task automatic check(input string req, input int actual, input int expected, input int tol);
      int diff;
      tests++;
      diff = actual - expected;
      if (diff < -tol || diff > tol) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, actual, expected, tol);
      end
   endtask

   task automatic send(input longint g, input logic v, input logic ok);
      @(negedge clk);
      gyro_rate  = g[31:0];
      gyro_valid = v;
      gyro_ok    = ok;
      @(negedge clk);
      gyro_valid = 1'b0;
      gyro_ok    = 1'b0;
   endtask

   // high cycles of the first complete pulse and distance to the next rise
   task automatic measure(output int hi, output int per);
      logic prev;
      int   guard;
      hi = -1; per = -1; guard = 0;
      prev = pwm_out;
      @(negedge clk);
      while (!(!prev && pwm_out) && guard < 3 * PER) begin
         prev = pwm_out; guard++;
         @(negedge clk);
      end
      if (guard >= 3 * PER) return;
      hi = 0;
      while (pwm_out) begin hi++; @(negedge clk); end
      per = hi;
      while (!pwm_out && per < 3 * PER) begin per++; @(negedge clk); end
   endtask

   task automatic level_case(input string req, input longint g);
      int hi, per;
      send(g, 1'b1, 1'b1);
      repeat (PER + 10) @(negedge clk);
      measure(hi, per);
      check(req, hi, exp_level(g) * TB_PS, TB_PS);
   endtask

   task automatic t_reset_low();
      int highs = 0;
      repeat (3 * PER) begin
         @(negedge clk);
         if (pwm_out) highs++;
      end
      check("R8 low after reset", highs, 0, 0);
   endtask

   task automatic t_zero_and_period();
      int hi, per;
      send(0, 1'b1, 1'b1);
      repeat (PER + 10) @(negedge clk);
      measure(hi, per);
      check("R3 zero rate midpoint", hi, (TB_TOP / 2) * TB_PS, TB_PS);
      check("R6 period", per, PER, 0);
      check("R9 prescaled period", per / TB_PS, TB_TOP + 1, 0);
   endtask

   task automatic t_rejects();
      int hi, per;
      level_case("R1 reference level", 64'sd655360000);
      send(-64'sd655360000, 1'b1, 1'b0);
      repeat (PER + 10) @(negedge clk);
      measure(hi, per);
      check("R5 bad frame held", hi, exp_level(655360000) * TB_PS, TB_PS);
      @(negedge clk);
      gyro_rate = 32'h8000_0000;
      gyro_ok   = 1'b1;
      repeat (PER + 10) @(negedge clk);
      gyro_ok = 1'b0;
      measure(hi, per);
      check("R5 no strobe held", hi, exp_level(655360000) * TB_PS, TB_PS);
   endtask

   task automatic t_wrap_only();
      int bad = 0, pulses = 0, run = 0;
      logic prev, seen_rise;
      int old_hi, new_hi, d1, d2;
      send(0, 1'b1, 1'b1);
      repeat (PER + 10) @(negedge clk);
      while (!pwm_out) @(negedge clk);
      repeat (100) @(negedge clk);
      send(64'sd1000000000, 1'b1, 1'b1);
      old_hi = exp_level(0) * TB_PS;
      new_hi = exp_level(1000000000) * TB_PS;
      prev = pwm_out; seen_rise = 1'b0;
      repeat (4 * PER) begin
         @(negedge clk);
         if (!prev && pwm_out) begin seen_rise = 1'b1; run = 0; end
         if (pwm_out) run++;
         if (prev && !pwm_out && seen_rise) begin
            pulses++;
            d1 = run - old_hi; d2 = run - new_hi;
            if (!((d1 >= -TB_PS && d1 <= TB_PS) || (d2 >= -TB_PS && d2 <= TB_PS))) bad++;
         end
         prev = pwm_out;
      end
      check("R7 no mixed pulse", bad, 0, 0);
      check("R7 pulses seen", pulses, 4, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset_low();
      t_zero_and_period();
      level_case("R1 positive rate", 64'sd655360000);
      level_case("R1 negative rate", -64'sd327680000);
      level_case("R1 small rate", 64'sd655);
      level_case("R2 clamp high", 64'sd2147483647);
      level_case("R2 clamp low", -64'sd2147483648);
      level_case("R4 upper window edge", 64'sd1310720000);
      level_case("R4 lower window edge", -64'sd1310720000);
      t_rejects();
      t_wrap_only();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule